// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the peripheral side of a serial register port that uses three wires: an active-low select, a serial clock and a single data line shared in both directions. Each frame opens with a six-bit register address, sent most significant bit first, followed by a direction bit. A write frame adds one filler bit and then a data byte. A read frame stops after the direction bit. It then leaves one clock with nobody driving the line, and after that the slave shifts the register contents back to the master.

The serial pins are brought into the system clock domain through a synchronizer chain, and the block detects the serial clock edges there. The master must therefore run the serial clock several times slower than the system clock. The data line is split into an input, an output and an output-enable, which drive an external tristate pad. The register file holds four registers: a scratch register, a read-only identity byte, a resolution code, and a power/ownership register. The resolution code and the power state are driven out to the display timing logic. Control of those outputs passes between the registers and the strap or hardware pins, depending on the ownership bit.

Top module: `tws_regslave`

## Requirements
- R1: Bits are taken on rising serial clock edges, MSB first. The first six bits of a frame form the register address. The seventh bit selects the direction: 1 for read, 0 for write.
- R2: A write frame is 16 clocks long: 6 address bits, the direction bit 0, one ignored filler bit and 8 data bits. The register is updated only once the sixteenth rising edge has been seen.
- R3: In a read frame, the slave keeps its output enable low through the eighth clock (the turnaround). It launches the 8 data bits MSB first on the falling edges that follow the 8th through the 15th rising edges. It releases the line after the falling edge that follows the 16th rising edge.
- R4: Address 0 is a scratch register that can be read and written, with a reset value of 0x00. A value written there, for example 0x55, reads back unchanged.
- R5: Address 1 reads the identity byte, made of the chip number (default 0xA) in bits 7:4 and the revision (default 0x3) in bits 3:0. Writes to address 1 have no effect.
- R6: Address 2 holds a 3-bit resolution code in bits 2:0. Its reset value is taken from the strap pins. Bits 7:3 read as zero.
- R7: Address 3 holds two bits. Bit 0 is power: 1 means active, 0 means standby. Bit 7 is ownership: 1 means software control. Both reset to 0, and the other bits read as zero.
- R8: When the ownership bit is 1, the resolution output and the active output come from the registers. When it is 0, the resolution output follows the strap pins and the active output follows the hardware power pin. The ownership output mirrors the bit.
- R9: When the select line goes high at any point, the frame is dropped, the slave returns to idle and releases the data line. A write that was cut short changes no register.
- R10: Addresses 4 to 63 read as 0x00, and writes to them change nothing.
- R11: After reset, the data line is released and the outputs follow the strap and hardware pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Data value the slave drives |
| sdio_oe | output | 1 | Pad output enable for the data line |
| strap_res | input | 3 | Resolution strap, sets the reset value and the hardware-controlled output |
| hw_active | input | 1 | Hardware power pin, 1 means active |
| res_code | output | 3 | Resolution code sent to the timing logic |
| pwr_active | output | 1 | 1 means active, 0 means standby |
| sw_own | output | 1 | 1 when software owns resolution and power |

## Verification
The assertions rely on three properties of the inputs. The select, clock and data pins change only at moments that the synchronizer samples cleanly. The serial clock stays at each level for more cycles than the synchronizer is deep. The select line is held high through reset. The bench meets these by driving every pin on the falling system clock edge, holding each serial clock phase for six system clocks, and keeping the select high until reset has been released. It also waits between frames long enough for the deselect to take effect before a new frame starts.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int CMD_BITS   = ADDR_W + 1;
    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int RES_W      = 3;
    localparam int PWR_BIT    = 0;
    localparam int OWN_BIT    = DATA_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_SCRATCH = 6'd0,
        REG_IDENT   = 6'd1,
        REG_MODE    = 6'd2,
        REG_POWER   = 6'd3
    } reg_addr_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic cs_act;
        logic rise;
        logic fall;
        logic din;
    } pin_evt_t;

    function automatic logic [DATA_W-1:0] pack_power(input logic own, input logic act);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[OWN_BIT] = own;
        v[PWR_BIT] = act;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input logic [RES_W-1:0] res);
        return {{(DATA_W-RES_W){1'b0}}, res};
    endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    input  logic     sdio_in,
    output pin_evt_t evt
);

    localparam logic [2:0] IDLE_PINS = 3'b100;

    logic [2:0] pipe [STAGES];
    logic       sclk_d;
    logic [2:0] last;

    assign last = pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= IDLE_PINS;
            sclk_d <= 1'b0;
        end else begin
            pipe[0] <= {cs_n, sclk, sdio_in};
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            sclk_d <= last[1];
        end
    end

    always_comb begin
        evt.cs_act = ~last[2];
        evt.rise   = last[1] & ~sclk_d;
        evt.fall   = ~last[1] & sclk_d;
        evt.din    = last[0];
    end

endmodule

// File: rtl/tws_frame.sv
module tws_frame
    import tws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr,
    output logic              sdo,
    output logic              oe,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_BITS);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0]    cnt;
    logic [CMD_BITS-1:0] cmd;
    logic [DATA_W-1:0]   rx;
    logic [DATA_W-1:0]   tx;
    logic                is_rd;
    logic [DATA_W-1:0]   rx_next;

    assign is_rd   = cmd[0];
    assign rd_addr = cmd[CMD_BITS-1:1];
    assign rx_next = {rx[DATA_W-2:0], evt.din};
    assign bit_cnt = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cmd <= '0;
            rx  <= '0;
            tx  <= '0;
            sdo <= 1'b0;
            oe  <= 1'b0;
            wr  <= '0;
        end else begin
            wr.vld <= 1'b0;
            if (!evt.cs_act) begin
                cnt <= '0;
                cmd <= '0;
                oe  <= 1'b0;
                sdo <= 1'b0;
            end else if (evt.rise) begin
                if (cnt < CNT_END) cnt <= cnt + 1'b1;
                if (cnt < CNT_CMD) cmd <= {cmd[CMD_BITS-2:0], evt.din};
                if (cnt >= CNT_DATA && cnt < CNT_END) rx <= rx_next;
                if (cnt == CNT_CMD && is_rd) tx <= rdata;
                if (cnt == CNT_LAST && !is_rd) begin
                    wr.vld  <= 1'b1;
                    wr.addr <= rd_addr;
                    wr.data <= rx_next;
                end
            end else if (evt.fall) begin
                if (is_rd && cnt >= CNT_DATA && cnt < CNT_END) begin
                    oe  <= 1'b1;
                    sdo <= tx[DATA_W-1];
                    tx  <= {tx[DATA_W-2:0], 1'b0};
                end else if (cnt == CNT_END) begin
                    oe  <= 1'b0;
                    sdo <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
    import tws_pkg::*;
#(
    parameter logic [3:0] CHIP_ID = 4'hA,
    parameter logic [3:0] VERSION = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RES_W-1:0]  strap_res,
    input  logic              hw_active,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output logic [RES_W-1:0]  res_code,
    output logic              pwr_active,
    output logic              sw_own
);

    logic [DATA_W-1:0] scratch;
    logic [RES_W-1:0]  res_q;
    logic              pwr_q;
    logic              own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch <= '0;
            res_q   <= strap_res;
            pwr_q   <= 1'b0;
            own_q   <= 1'b0;
        end else if (wr.vld) begin
            case (wr.addr)
                REG_SCRATCH: scratch <= wr.data;
                REG_MODE:    res_q   <= wr.data[RES_W-1:0];
                REG_POWER: begin
                    pwr_q <= wr.data[PWR_BIT];
                    own_q <= wr.data[OWN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            REG_SCRATCH: rdata = scratch;
            REG_IDENT:   rdata = {CHIP_ID, VERSION};
            REG_MODE:    rdata = pack_mode(res_q);
            REG_POWER:   rdata = pack_power(own_q, pwr_q);
            default:     rdata = '0;
        endcase
    end

    assign res_code   = own_q ? res_q : strap_res;
    assign pwr_active = own_q ? pwr_q : hw_active;
    assign sw_own     = own_q;

endmodule

// File: rtl/tws_regslave.sv
module tws_regslave
    import tws_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] CHIP_ID     = 4'hA,
    parameter logic [3:0] VERSION     = 4'h3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdio_in,
    output logic             sdio_out,
    output logic             sdio_oe,
    input  logic [RES_W-1:0] strap_res,
    input  logic             hw_active,
    output logic [RES_W-1:0] res_code,
    output logic             pwr_active,
    output logic             sw_own
);

    pin_evt_t          evt;
    wr_req_t           wr_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rdata;
    logic [CNT_W-1:0]  bit_cnt;

    tws_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdio_in (sdio_in),
        .evt     (evt)
    );

    tws_frame frame_i (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rdata   (rdata),
        .rd_addr (rd_addr),
        .wr      (wr_req),
        .sdo     (sdio_out),
        .oe      (sdio_oe),
        .bit_cnt (bit_cnt)
    );

    tws_regfile #(.CHIP_ID(CHIP_ID), .VERSION(VERSION)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .strap_res  (strap_res),
        .hw_active  (hw_active),
        .wr         (wr_req),
        .rd_addr    (rd_addr),
        .rdata      (rdata),
        .res_code   (res_code),
        .pwr_active (pwr_active),
        .sw_own     (sw_own)
    );

endmodule

// File: rtl/tws_regslave_chk.sv
module tws_regslave_chk
    import tws_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             cs_act,
    input logic             sdio_oe,
    input logic             wr_vld,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             sw_own,
    input logic [RES_W-1:0] res_code
);

    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 3'd1;
    end

    // R9
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdio_oe);

    // R9
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd1 && wr_vld) |-> $past(cs_act));

    // R2
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_vld |=> !wr_vld);

    // R3
    oe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdio_oe) |-> (bit_cnt == CNT_W'(DATA_W)));

    // R8
    own_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_own && !wr_vld) |=> $stable(res_code));

endmodule

bind tws_regslave tws_regslave_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .cs_act   (evt.cs_act),
    .sdio_oe  (sdio_oe),
    .wr_vld   (wr_req.vld),
    .bit_cnt  (bit_cnt),
    .sw_own   (sw_own),
    .res_code (res_code)
);

// File: tb/tws_regslave_tb_top.sv
module tws_regslave_tb_top;

    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdio_in = 1'b0;
    logic       hw_active = 1'b1;
    logic [2:0] strap_res = 3'b101;
    logic       sdio_out;
    logic       sdio_oe;
    logic [2:0] res_code;
    logic       pwr_active;
    logic       sw_own;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tws_regslave dut_i (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdio_in    (sdio_in),
        .sdio_out   (sdio_out),
        .sdio_oe    (sdio_oe),
        .strap_res  (strap_res),
        .hw_active  (hw_active),
        .res_code   (res_code),
        .pwr_active (pwr_active),
        .sw_own     (sw_own)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [5:0] a, input logic rd, input logic [7:0] wd,
                             input int nclk, output logic [7:0] rv,
                             output logic early_oe, output logic late_oe);
        logic [7:0] cmd;
        cmd      = {a, rd, 1'b0};
        rv       = '0;
        early_oe = 1'b0;
        late_oe  = 1'b1;
        cs_n     = 1'b0;
        wclk(HP);
        for (int i = 0; i < nclk; i++) begin
            if (i < 8) sdio_in = cmd[7-i];
            else       sdio_in = rd ? 1'b0 : wd[15-i];
            wclk(HP);
            if (i < 8) early_oe = early_oe | sdio_oe;
            else if (rd) begin
                rv[15-i] = sdio_out;
                late_oe  = late_oe & sdio_oe;
            end
            sclk = 1'b1;
            wclk(HP);
            if (i < 8) early_oe = early_oe | sdio_oe;
            sclk = 1'b0;
        end
        wclk(HP);
        cs_n    = 1'b1;
        sdio_in = 1'b0;
        wclk(HP);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] rv;
        logic eo, lo;
        run_frame(a, 1'b0, d, 16, rv, eo, lo);
        chk("R2 slave silent during write", eo, 1'b0);
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] d);
        logic eo, lo;
        run_frame(a, 1'b1, 8'h00, 16, d, eo, lo);
        chk("R3 no drive before turnaround ends", eo, 1'b0);
        chk("R3 drive during data bits", lo, 1'b1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R11 oe after reset", sdio_oe, 1'b0);
        chk("R11 res_code follows strap", res_code, 3'b101);
        chk("R11 pwr follows hw pin", pwr_active, 1'b1);
        chk("R11 ownership clear", sw_own, 1'b0);
        do_read(6'd0, v); chk("R4 scratch reset 0x00", v, 8'h00);
        do_read(6'd2, v); chk("R6 mode reset from strap", v, 8'h05);
        do_read(6'd3, v); chk("R7 power reg reset", v, 8'h00);
        chk("R11 oe idle after reads", sdio_oe, 1'b0);
    endtask

    task automatic t_scratch();
        logic [7:0] v;
        do_write(6'd0, 8'h55);
        do_read(6'd0, v); chk("R4 scratch 0x55 readback", v, 8'h55);
        do_write(6'd0, 8'h3C);
        do_read(6'd0, v); chk("R1 R4 scratch 0x3C readback", v, 8'h3C);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        do_read(6'd1, v); chk("R5 identity byte", v, 8'hA3);
        do_write(6'd1, 8'hFF);
        do_read(6'd1, v); chk("R5 identity unchanged by write", v, 8'hA3);
        do_read(6'd0, v); chk("R1 write to addr 1 spares scratch", v, 8'h3C);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        do_write(6'd2, 8'hFE);
        do_read(6'd2, v); chk("R6 mode upper bits zero", v, 8'h06);
        chk("R8 hw owned res follows strap", res_code, 3'b101);
    endtask

    task automatic t_power();
        logic [7:0] v;
        do_write(6'd3, 8'h81);
        do_read(6'd3, v); chk("R7 power reg readback", v, 8'h81);
        chk("R8 sw res_code", res_code, 3'b110);
        chk("R8 sw active", pwr_active, 1'b1);
        chk("R8 sw_own out", sw_own, 1'b1);
        hw_active = 1'b0;
        wclk(2);
        chk("R8 hw pin ignored when sw owns", pwr_active, 1'b1);
        do_write(6'd3, 8'h00);
        chk("R8 hw owned pwr follows pin", pwr_active, 1'b0);
        chk("R8 hw owned res back to strap", res_code, 3'b101);
        hw_active = 1'b1;
        do_write(6'd3, 8'h7E);
        do_read(6'd3, v); chk("R7 unused power bits zero", v, 8'h00);
        do_write(6'd3, 8'h80);
        chk("R7 standby under sw", pwr_active, 1'b0);
        chk("R7 ownership set", sw_own, 1'b1);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        logic eo, lo;
        run_frame(6'd0, 1'b0, 8'h12, 12, v, eo, lo);
        do_read(6'd0, v); chk("R9 partial write dropped", v, 8'h3C);
        run_frame(6'd2, 1'b0, 8'h01, 15, v, eo, lo);
        do_read(6'd2, v); chk("R9 15-clock write dropped", v, 8'h06);
        run_frame(6'd1, 1'b1, 8'h00, 12, v, eo, lo);
        chk("R9 line released after aborted read", sdio_oe, 1'b0);
        do_read(6'd1, v); chk("R9 next frame decodes cleanly", v, 8'hA3);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        do_write(6'd32, 8'h77);
        do_read(6'd32, v); chk("R10 addr 32 reads zero", v, 8'h00);
        do_read(6'd0, v); chk("R10 addr 32 does not alias scratch", v, 8'h3C);
        do_write(6'd63, 8'hFF);
        do_read(6'd63, v); chk("R10 addr 63 reads zero", v, 8'h00);
        do_write(6'd6, 8'h81);
        do_read(6'd2, v); chk("R10 addr 6 does not alias mode", v, 8'h06);
        do_read(6'd3, v); chk("R10 power reg untouched", v, 8'h80);
    endtask

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(4);
        t_reset();
        t_scratch();
        t_ident();
        t_mode();
        t_power();
        t_abort();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule